// File: doc/BRIEF.md
# Oscillator Frequency Word Shadow/Active Update Controller

This block holds the tuning word of a numerically controlled oscillator as a pair of registers. Software writes the word, one half at a time, into a shadow copy. The oscillator sees only the active copy. The active copy is loaded from the shadow only when an update event arrives and a programmable hold-off delay has run out. This lets a new frequency be staged at any time and then applied at a known moment.

There are two kinds of update event. One is a single-cycle sync hop pulse. The other is the channel waking, which is seen as the sleep level going from high to low. Every event loads a down-counter from the hold-off register. The shadow value moves into the active register on the edge where the counter is at one. A hold-off of one therefore applies the word on the event edge itself, and a hold-off of zero means no update ever happens. Reads of the frequency addresses return the active word and never the shadow.

Top module: `nco_freq_shadow_ctrl`

## Requirements
- R1: After reset the active word is zero and the transfer strobe is low. Reads of address 0 and address 1 return zero.
- R2: A write to address 0 sets the low 16 bits of the shadow word. A write to address 1 sets the high 16 bits. No write changes the active word, and reads of addresses 0 and 1 return the low and high halves of the active word.
- R3: When a sync hop pulse is sampled and the hold-off H is 2 or more, the active word takes the shadow value on the clock edge H-1 cycles after the event edge. The strobe is high for exactly the one cycle after that edge.
- R4: With a hold-off of 1, the active word is updated on the event edge itself, and the strobe is high in the following cycle.
- R5: With a hold-off of 0, an event causes no transfer. Such an event also cancels any countdown that is in progress.
- R6: A high-to-low change of the sleep input is an update event. A low-to-high change of the sleep input is not.
- R7: An event that arrives during a countdown reloads the counter from the hold-off register. The transfer then happens H-1 cycles after the new event.
- R8: The value copied is the shadow word as it stands at the transfer edge, including writes made during the countdown.
- R9: Address 2 writes and reads the 16-bit hold-off value. Reads of address 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 low half, 1 high half, 2 hold-off |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address (combinational readback) |
| rd_data | output | 16 | Read data: active halves, hold-off, or zero |
| sync_hop | input | 1 | Single-cycle update event pulse |
| sleep | input | 1 | Channel sleep level; falling edge is an update event |
| active_freq | output | 32 | Active frequency word driving the oscillator |
| xfer_strobe | output | 1 | One-cycle flag after each shadow-to-active transfer |

## Verification
The bench builds the block with its default parameters: a 32-bit word split into two 16-bit halves, and a 16-bit hold-off. At these values both halves of the shadow are reachable through the write port. Hold-off values from zero to six then cover all of the following: the blocking value, the immediate value, normal countdowns, a retrigger partway through a count, and a cancel partway through a count. All of these finish within a few cycles, so each edge on which the active word may change can be sampled exactly.

// File: rtl/nco_shd_pkg.sv
package nco_shd_pkg;

  // Returns the count to hold after the current edge.
  function automatic logic [31:0] count_next(input logic [31:0] cur);
    return (cur > 32'd1) ? cur - 32'd1 : 32'd0;
  endfunction

  // Returns 1 when the current count calls for the shadow-to-active move.
  function automatic logic count_fires(input logic [31:0] cur);
    return cur == 32'd1;
  endfunction

endpackage

// File: rtl/nco_shd_regfile.sv
module nco_shd_regfile #(
  parameter int FREQ_W = 32,
  parameter int DATA_W = 16,
  parameter int HOLD_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [FREQ_W-1:0] shadow_o,
  output logic [HOLD_W-1:0] hold_o
);
  localparam int N_HALF = FREQ_W / DATA_W;

  logic [DATA_W-1:0] half_q [N_HALF];
  logic [HOLD_W-1:0] hold_q;

  for (genvar g = 0; g < N_HALF; g++) begin : g_half
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        half_q[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g))
        half_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(N_HALF))
      hold_q <= wr_data[HOLD_W-1:0];
  end

  always_comb begin
    shadow_o = '0;
    for (int i = 0; i < N_HALF; i++)
      shadow_o[i*DATA_W +: DATA_W] = half_q[i];
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/nco_shd_trigger.sv
module nco_shd_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_hop,
  input  logic sleep,
  output logic wake_o,
  output logic trig_o
);
  logic sleep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sleep_q <= 1'b0;
    else        sleep_q <= sleep;
  end

  assign wake_o = sleep_q & ~sleep;
  assign trig_o = sync_hop | wake_o;
endmodule

// File: rtl/nco_shd_holdoff_cnt.sv
module nco_shd_holdoff_cnt
  import nco_shd_pkg::*;
#(
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [HOLD_W-1:0] hold,
  output logic [HOLD_W-1:0] cnt_o,
  output logic              fire_o
);
  logic [HOLD_W-1:0] cnt_q;
  logic [HOLD_W-1:0] cur;

  // A trigger takes priority and replaces any count in progress.
  assign cur    = trig ? hold : cnt_q;
  assign fire_o = count_fires(32'(cur));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= HOLD_W'(count_next(32'(cur)));
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/nco_freq_shadow_ctrl.sv
module nco_freq_shadow_ctrl #(
  parameter int FREQ_W = 32,
  parameter int DATA_W = 16,
  parameter int HOLD_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sync_hop,
  input  logic              sleep,
  output logic [FREQ_W-1:0] active_freq,
  output logic              xfer_strobe
);
  localparam int N_HALF = FREQ_W / DATA_W;

  logic [FREQ_W-1:0] shadow_q;
  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] cnt_q;
  logic              wake_w;
  logic              trig_w;
  logic              fire_w;
  logic [FREQ_W-1:0] active_q;
  logic              strobe_q;

  nco_shd_regfile #(
    .FREQ_W(FREQ_W), .DATA_W(DATA_W), .HOLD_W(HOLD_W), .ADDR_W(ADDR_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .shadow_o(shadow_q), .hold_o(hold_q)
  );

  nco_shd_trigger trig_i (
    .clk(clk), .rst_n(rst_n), .sync_hop(sync_hop), .sleep(sleep),
    .wake_o(wake_w), .trig_o(trig_w)
  );

  nco_shd_holdoff_cnt #(.HOLD_W(HOLD_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .trig(trig_w), .hold(hold_q),
    .cnt_o(cnt_q), .fire_o(fire_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= fire_w;
      if (fire_w) active_q <= shadow_q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_HALF; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = active_q[i*DATA_W +: DATA_W];
    if (rd_addr == ADDR_W'(N_HALF)) rd_data = DATA_W'(hold_q);
  end

  assign active_freq = active_q;
  assign xfer_strobe = strobe_q;
endmodule

// File: rtl/nco_shd_checker.sv
module nco_shd_checker #(
  parameter int FREQ_W = 32,
  parameter int HOLD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig,
  input logic [HOLD_W-1:0] hold_q,
  input logic [HOLD_W-1:0] cnt_q,
  input logic [FREQ_W-1:0] shadow_q,
  input logic [FREQ_W-1:0] active_freq,
  input logic              xfer_strobe
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (active_freq == '0 && !xfer_strobe));

  assert_active_only_on_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_strobe |-> $stable(active_freq));

  assert_countdown_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > HOLD_W'(1) && !trig) |=> cnt_q == $past(cnt_q) - HOLD_W'(1));

  assert_immediate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && hold_q == HOLD_W'(1)) |=> xfer_strobe);

  assert_zero_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && hold_q == '0) |=> !xfer_strobe);

  assert_no_early_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && hold_q > HOLD_W'(1)) |=> !xfer_strobe);

  assert_copy_shadow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_strobe |-> active_freq == $past(shadow_q));
endmodule

bind nco_freq_shadow_ctrl nco_shd_checker #(
  .FREQ_W(FREQ_W), .HOLD_W(HOLD_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .trig(trig_w), .hold_q(hold_q), .cnt_q(cnt_q),
  .shadow_q(shadow_q), .active_freq(active_freq), .xfer_strobe(xfer_strobe)
);

// File: tb/nco_freq_shadow_ctrl_tb.sv
module nco_freq_shadow_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        sync_hop = 1'b0;
  logic        sleep = 1'b0;
  logic [31:0] active_freq;
  logic        xfer_strobe;

  int n_tests = 0;
  int n_fail  = 0;
  int strobe_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nco_freq_shadow_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sync_hop(sync_hop), .sleep(sleep), .active_freq(active_freq),
    .xfer_strobe(xfer_strobe)
  );

  always @(negedge clk) if (xfer_strobe) strobe_seen++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_word(input logic [31:0] w);
    wr(2'd0, w[15:0]);
    wr(2'd1, w[31:16]);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  // Returns just after the event edge has passed.
  task automatic pulse_sync();
    sync_hop = 1'b1;
    @(negedge clk);
    sync_hop = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk_eq("R1 active", active_freq, 32'h0);
    chk_eq("R1 strobe", {31'b0, xfer_strobe}, 32'h0);
    rd(2'd0, d); chk_eq("R1 rd0", {16'h0, d}, 32'h0);
    rd(2'd1, d); chk_eq("R1 rd1", {16'h0, d}, 32'h0);
  endtask

  task automatic t_write_shadow();
    logic [15:0] d;
    wr_word(32'hABCD_1234);
    wr(2'd2, 16'd4);
    chk_eq("R2 active untouched", active_freq, 32'h0);
    rd(2'd0, d); chk_eq("R2 rd0 active", {16'h0, d}, 32'h0);
    rd(2'd1, d); chk_eq("R2 rd1 active", {16'h0, d}, 32'h0);
    rd(2'd2, d); chk_eq("R9 holdoff rd", {16'h0, d}, 32'd4);
    rd(2'd3, d); chk_eq("R9 addr3 zero", {16'h0, d}, 32'h0);
  endtask

  task automatic t_sync_delay();
    logic [15:0] d;
    pulse_sync();
    wait_n(2);
    chk_eq("R3 before due", active_freq, 32'h0);
    chk_eq("R3 no strobe", {31'b0, xfer_strobe}, 32'h0);
    wait_n(1);
    chk_eq("R3 transferred", active_freq, 32'hABCD_1234);
    chk_eq("R3 strobe high", {31'b0, xfer_strobe}, 32'h1);
    wait_n(1);
    chk_eq("R3 strobe one cycle", {31'b0, xfer_strobe}, 32'h0);
    rd(2'd0, d); chk_eq("R2 rd0 low half", {16'h0, d}, 32'h1234);
    rd(2'd1, d); chk_eq("R2 rd1 high half", {16'h0, d}, 32'hABCD);
  endtask

  task automatic t_immediate();
    wr(2'd2, 16'd1);
    wr_word(32'h0000_5555);
    pulse_sync();
    chk_eq("R4 immediate", active_freq, 32'h0000_5555);
    chk_eq("R4 strobe", {31'b0, xfer_strobe}, 32'h1);
  endtask

  task automatic t_zero();
    int s0;
    wr(2'd2, 16'd0);
    wr_word(32'h1111_2222);
    s0 = strobe_seen;
    pulse_sync();
    wait_n(20);
    chk_eq("R5 blocked", active_freq, 32'h0000_5555);
    chk_eq("R5 no strobe", 32'(strobe_seen - s0), 32'h0);
    wr(2'd2, 16'd6);
    pulse_sync();
    wait_n(1);
    wr(2'd2, 16'd0);
    pulse_sync();
    wait_n(20);
    chk_eq("R5 cancel countdown", active_freq, 32'h0000_5555);
  endtask

  task automatic t_wake();
    wr(2'd2, 16'd3);
    wr_word(32'h3333_4444);
    sleep = 1'b1;
    wait_n(10);
    chk_eq("R6 enter sleep no update", active_freq, 32'h0000_5555);
    sleep = 1'b0;
    @(negedge clk);
    wait_n(1);
    chk_eq("R6 wake before due", active_freq, 32'h0000_5555);
    wait_n(1);
    chk_eq("R6 wake transfer", active_freq, 32'h3333_4444);
  endtask

  task automatic t_retrig();
    wr(2'd2, 16'd5);
    wr_word(32'h7777_8888);
    pulse_sync();
    wait_n(3);
    pulse_sync();
    wait_n(3);
    chk_eq("R7 reload delays", active_freq, 32'h3333_4444);
    wait_n(1);
    chk_eq("R7 transfer after reload", active_freq, 32'h7777_8888);
  endtask

  task automatic t_shadow_change();
    wr(2'd2, 16'd6);
    wr_word(32'h0A0A_0B0B);
    pulse_sync();
    wait_n(1);
    wr_word(32'hC0DE_F00D);
    wait_n(1);
    chk_eq("R8 before due", active_freq, 32'h7777_8888);
    wait_n(1);
    chk_eq("R8 latest shadow copied", active_freq, 32'hC0DE_F00D);
  endtask

  initial begin
    fork
      begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_shadow();
        t_sync_delay();
        t_immediate();
        t_zero();
        t_wake();
        t_retrig();
        t_shadow_change();
        done = 1'b1;
      end
      begin
        wait_n(5000);
        if (!done) begin
          n_tests++; n_fail++;
          $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        end
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule